// File: doc/BRIEF.md
# USB Endpoint Stall Handshake Controller

This block holds the halt state of every device endpoint and decides, for each IN or OUT token, whether the device answers normally or returns a STALL handshake. Firmware sets one command bit per endpoint. The request decoder reports each CLEAR_FEATURE(ENDPOINT_HALT) as a one-cycle strobe with an endpoint number. The packet engine reports the start of each token and the end of each transaction.

A halt that is requested while a transaction is running lets that transaction finish. The halt takes effect from the next token. A halt that firmware keeps asserted can be lifted by the host. After that it is armed again only when firmware writes a new 0-to-1 edge on the command bit.

Isochronous endpoints have no handshake phase, so they are never reported as halted. Endpoint 0 has one halt bit, and that bit governs both directions. For each endpoint a hold flag tells the transmit FIFO to keep its queued data. The data is released once the halt is lifted.

Top module: `usb_stall_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stall_status_o`, `hold_tx_o`, `resp_active_o` and `resp_stall_o` are all zero.
- R2: A 0-to-1 change of `cmd_stall_i[n]` for an endpoint with `iso_ep_i[n]`=0 sets `stall_status_o[n]` on the next clock edge.
- R3: A halt whose command bit stays at 1 is ended by a CLEAR_FEATURE strobe for that endpoint. It does not come back while the bit stays at 1. It is set again only after the bit returns to 0 and then rises again.
- R4: When `cmd_stall_i[n]` is 0, `stall_status_o[n]` is 0 after the next clock edge.
- R5: A CLEAR_FEATURE strobe and a 0-to-1 command edge for the same endpoint in the same cycle leave the endpoint not halted.
- R6: One edge after `tok_start_i`, `resp_active_o` is 1. At the same edge `resp_stall_o` equals `stall_status_o[tok_ep_i]` as it was in the token-start cycle, and `resp_in_o` equals `tok_in_i`. Both outputs hold until `xact_end_i` clears them one edge later. While `resp_active_o` is 0, `resp_stall_o` is 0.
- R7: A halt change during a transaction does not change `resp_stall_o` for that transaction. The next token on that endpoint sees the new state.
- R8: An endpoint with `iso_ep_i[n]`=1 never shows `stall_status_o[n]`=1, never gets `resp_stall_o`=1, and never has `hold_tx_o[n]`=1.
- R9: `hold_tx_o[n]` follows `stall_status_o[n]` one edge later. The exception is while an unstalled transaction on endpoint n is active: then the hold is 0, so the running transfer completes. The hold is released one edge after the halt ends.
- R10: Endpoint 0 has one halt bit. When it is set, both IN and OUT tokens on endpoint 0 get `resp_stall_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stall_i | input | NUM_EP | Firmware halt command bits, one per endpoint |
| iso_ep_i | input | NUM_EP | Endpoint is isochronous |
| clr_feat_i | input | 1 | CLEAR_FEATURE(ENDPOINT_HALT) strobe |
| clr_feat_ep_i | input | $clog2(NUM_EP) | Endpoint addressed by the clear strobe |
| tok_start_i | input | 1 | Token received, one-cycle strobe |
| tok_ep_i | input | $clog2(NUM_EP) | Endpoint of the token |
| tok_in_i | input | 1 | 1 = IN token, 0 = OUT token |
| xact_end_i | input | 1 | Current transaction finished, one-cycle strobe |
| resp_active_o | output | 1 | A transaction decision is in force |
| resp_stall_o | output | 1 | Answer the current transaction with STALL |
| resp_in_o | output | 1 | Direction of the current transaction |
| stall_status_o | output | NUM_EP | Effective halt state per endpoint, readable by firmware |
| hold_tx_o | output | NUM_EP | Transmit FIFO must keep its data |

## Verification
The halt status responds one edge after a command-bit change or a clear strobe. The token decision appears one edge after `tok_start_i` and is dropped one edge after `xact_end_i`. The hold flag lags the status by one further edge, because it is built from the registered status. The bench drives inputs on the falling edge and samples on the next falling edge. Each directed check therefore counts those edges explicitly, stepping one edge for status and decision and two for hold. In the random phase a cycle-level reference model, advanced on the same rising edge, is compared with every output after each edge.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;
  typedef struct packed {
    logic active;
    logic stall;
    logic dir_in;
  } resp_t;
endpackage

// File: rtl/stall_latch_bank.sv
module stall_latch_bank #(
  parameter int NUM_EP = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] cmd_i,
  input  logic [NUM_EP-1:0] iso_i,
  input  logic              clr_i,
  input  logic [EPW-1:0]    clr_ep_i,
  output logic [NUM_EP-1:0] eff_o
);
  logic [NUM_EP-1:0] cmd_q;
  logic [NUM_EP-1:0] arm_q;
  logic [NUM_EP-1:0] arm_d;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic hit;
    logic rise;
    assign hit  = clr_i && (clr_ep_i == EPW'(g));
    assign rise = cmd_i[g] && !cmd_q[g];

    always_comb begin
      if (hit || !cmd_i[g]) arm_d[g] = 1'b0;
      else if (rise)        arm_d[g] = 1'b1;
      else                  arm_d[g] = arm_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      arm_q <= '0;
      eff_o <= '0;
    end else begin
      cmd_q <= cmd_i;
      arm_q <= arm_d;
      eff_o <= arm_d & ~iso_i;
    end
  end
endmodule

// File: rtl/token_decider.sv
module token_decider
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_start_i,
  input  logic [EPW-1:0]    tok_ep_i,
  input  logic              tok_in_i,
  input  logic              xact_end_i,
  input  logic [NUM_EP-1:0] eff_i,
  output resp_t             resp_o,
  output logic [EPW-1:0]    ep_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_o <= '0;
      ep_o   <= '0;
    end else if (tok_start_i) begin
      resp_o.active <= 1'b1;
      resp_o.stall  <= eff_i[tok_ep_i];
      resp_o.dir_in <= tok_in_i;
      ep_o          <= tok_ep_i;
    end else if (xact_end_i) begin
      resp_o <= '0;
    end
  end
endmodule

// File: rtl/hold_gen.sv
module hold_gen
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] eff_i,
  input  resp_t             resp_i,
  input  logic [EPW-1:0]    ep_i,
  output logic [NUM_EP-1:0] hold_o
);
  logic [NUM_EP-1:0] keep_open;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    assign keep_open[g] = resp_i.active && !resp_i.stall && (ep_i == EPW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) hold_o <= '0;
    else     hold_o <= eff_i & ~keep_open;
  end
endmodule

// File: rtl/usb_stall_ctrl.sv
module usb_stall_ctrl
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] cmd_stall_i,
  input  logic [NUM_EP-1:0] iso_ep_i,
  input  logic              clr_feat_i,
  input  logic [EPW-1:0]    clr_feat_ep_i,
  input  logic              tok_start_i,
  input  logic [EPW-1:0]    tok_ep_i,
  input  logic              tok_in_i,
  input  logic              xact_end_i,
  output logic              resp_active_o,
  output logic              resp_stall_o,
  output logic              resp_in_o,
  output logic [NUM_EP-1:0] stall_status_o,
  output logic [NUM_EP-1:0] hold_tx_o
);
  logic [NUM_EP-1:0] eff;
  resp_t             resp;
  logic [EPW-1:0]    cur_ep;

  stall_latch_bank #(.NUM_EP(NUM_EP)) latch_i (
    .clk(clk), .rst(rst), .cmd_i(cmd_stall_i), .iso_i(iso_ep_i),
    .clr_i(clr_feat_i), .clr_ep_i(clr_feat_ep_i), .eff_o(eff)
  );

  token_decider #(.NUM_EP(NUM_EP)) decide_i (
    .clk(clk), .rst(rst), .tok_start_i(tok_start_i), .tok_ep_i(tok_ep_i),
    .tok_in_i(tok_in_i), .xact_end_i(xact_end_i), .eff_i(eff),
    .resp_o(resp), .ep_o(cur_ep)
  );

  hold_gen #(.NUM_EP(NUM_EP)) hold_i (
    .clk(clk), .rst(rst), .eff_i(eff), .resp_i(resp), .ep_i(cur_ep),
    .hold_o(hold_tx_o)
  );

  assign stall_status_o = eff;
  assign resp_active_o  = resp.active;
  assign resp_stall_o   = resp.stall;
  assign resp_in_o      = resp.dir_in;
endmodule

// File: rtl/usb_stall_ctrl_chk.sv
module usb_stall_ctrl_chk #(
  parameter int NUM_EP = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EP-1:0] cmd_stall_i,
  input logic [NUM_EP-1:0] iso_ep_i,
  input logic              clr_feat_i,
  input logic [EPW-1:0]    clr_feat_ep_i,
  input logic              tok_start_i,
  input logic [EPW-1:0]    tok_ep_i,
  input logic              tok_in_i,
  input logic              xact_end_i,
  input logic              resp_active_o,
  input logic              resp_stall_o,
  input logic              resp_in_o,
  input logic [NUM_EP-1:0] stall_status_o,
  input logic [NUM_EP-1:0] hold_tx_o
);
  assert_cmd_low_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stall_status_o & ~$past(cmd_stall_i)) == '0));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr_feat_i |=> !stall_status_o[$past(clr_feat_ep_i)]);

  assert_decision_R6: assert property (@(posedge clk) disable iff (rst)
    tok_start_i |=> (resp_active_o && (resp_stall_o == $past(stall_status_o[tok_ep_i]))));

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !resp_active_o |-> !resp_stall_o);

  assert_hold_decision_R7: assert property (@(posedge clk) disable iff (rst)
    (resp_active_o && !tok_start_i && !xact_end_i) |=> $stable(resp_stall_o));

  assert_iso_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stall_status_o & $past(iso_ep_i)) == '0));

  assert_hold_subset_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((hold_tx_o & ~$past(stall_status_o)) == '0));
endmodule

bind usb_stall_ctrl usb_stall_ctrl_chk #(.NUM_EP(NUM_EP)) chk_i (.*);

// File: tb/usb_stall_ctrl_tb_top.sv
module usb_stall_ctrl_tb_top;
  localparam int NUM_EP = 8;
  localparam int EPW = $clog2(NUM_EP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_EP-1:0] cmd_stall_i = '0;
  logic [NUM_EP-1:0] iso_ep_i = 8'h80;
  logic clr_feat_i = 1'b0;
  logic [EPW-1:0] clr_feat_ep_i = '0;
  logic tok_start_i = 1'b0;
  logic [EPW-1:0] tok_ep_i = '0;
  logic tok_in_i = 1'b0;
  logic xact_end_i = 1'b0;
  logic resp_active_o, resp_stall_o, resp_in_o;
  logic [NUM_EP-1:0] stall_status_o, hold_tx_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_stall_ctrl #(.NUM_EP(NUM_EP)) dut_i (.*);

  // reference model, built from the requirements
  logic [NUM_EP-1:0] m_prev, m_arm, m_eff, m_hold;
  logic m_act, m_stall, m_in;
  logic [EPW-1:0] m_ep;

  function automatic logic [NUM_EP-1:0] next_arm(logic [NUM_EP-1:0] arm, logic [NUM_EP-1:0] prev,
                                                 logic [NUM_EP-1:0] cmd, logic clr, logic [EPW-1:0] cep);
    logic [NUM_EP-1:0] r;
    for (int i = 0; i < NUM_EP; i++) begin
      if ((clr && cep == EPW'(i)) || !cmd[i]) r[i] = 1'b0;
      else if (!prev[i]) r[i] = 1'b1;
      else r[i] = arm[i];
    end
    return r;
  endfunction

  function automatic logic [NUM_EP-1:0] next_hold(logic [NUM_EP-1:0] eff, logic act, logic st,
                                                  logic [EPW-1:0] ep);
    logic [NUM_EP-1:0] r = eff;
    if (act && !st) r[ep] = 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prev <= '0; m_arm <= '0; m_eff <= '0; m_hold <= '0;
      m_act <= 1'b0; m_stall <= 1'b0; m_in <= 1'b0; m_ep <= '0;
    end else begin
      logic [NUM_EP-1:0] na;
      na = next_arm(m_arm, m_prev, cmd_stall_i, clr_feat_i, clr_feat_ep_i);
      m_prev <= cmd_stall_i;
      m_arm  <= na;
      m_eff  <= na & ~iso_ep_i;
      m_hold <= next_hold(m_eff, m_act, m_stall, m_ep);
      if (tok_start_i) begin
        m_act <= 1'b1; m_stall <= m_eff[tok_ep_i]; m_in <= tok_in_i; m_ep <= tok_ep_i;
      end else if (xact_end_i) begin
        m_act <= 1'b0; m_stall <= 1'b0; m_in <= 1'b0;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic token(logic [EPW-1:0] ep, logic dir_in);
    tok_start_i = 1'b1; tok_ep_i = ep; tok_in_i = dir_in;
    step();
    tok_start_i = 1'b0;
  endtask

  task automatic finish_xact();
    xact_end_i = 1'b1;
    step();
    xact_end_i = 1'b0;
  endtask

  task automatic compare_model();
    check("R2 status vs model", 32'(stall_status_o), 32'(m_eff));
    check("R6 active vs model", 32'(resp_active_o), 32'(m_act));
    check("R7 stall vs model", 32'(resp_stall_o), 32'(m_stall));
    check("R6 dir vs model", 32'(resp_in_o), 32'(m_in));
    check("R9 hold vs model", 32'(hold_tx_o), 32'(m_hold));
  endtask

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    check("R1 status in reset", 32'(stall_status_o), 0);
    check("R1 active in reset", 32'(resp_active_o), 0);
    rst = 1'b0;
    step();
    check("R1 hold after reset", 32'(hold_tx_o), 0);
    check("R1 stall after reset", 32'(resp_stall_o), 0);

    cmd_stall_i[3] = 1'b1;
    step();
    check("R2 set ep3", 32'(stall_status_o[3]), 1);
    step();
    check("R9 hold ep3", 32'(hold_tx_o[3]), 1);

    token(3, 1'b1);
    check("R6 active", 32'(resp_active_o), 1);
    check("R6 stall ep3", 32'(resp_stall_o), 1);
    check("R6 dir", 32'(resp_in_o), 1);
    finish_xact();
    check("R6 end", 32'({resp_active_o, resp_stall_o}), 0);

    token(2, 1'b0);
    check("R7 open ep2", 32'(resp_stall_o), 0);
    cmd_stall_i[2] = 1'b1;
    step();
    step();
    check("R7 status mid", 32'(stall_status_o[2]), 1);
    check("R7 kept mid", 32'(resp_stall_o), 0);
    check("R9 no hold mid", 32'(hold_tx_o[2]), 0);
    finish_xact();
    step();
    check("R9 hold after end", 32'(hold_tx_o[2]), 1);
    token(2, 1'b0);
    check("R7 next token", 32'(resp_stall_o), 1);
    finish_xact();

    clr_feat_i = 1'b1; clr_feat_ep_i = 3;
    step();
    clr_feat_i = 1'b0;
    check("R3 cleared", 32'(stall_status_o[3]), 0);
    step();
    check("R9 released", 32'(hold_tx_o[3]), 0);
    step();
    check("R3 no rearm", 32'(stall_status_o[3]), 0);
    check("R3 ep2 untouched", 32'(stall_status_o[2]), 1);
    cmd_stall_i[3] = 1'b0;
    step();
    cmd_stall_i[3] = 1'b1;
    step();
    check("R3 rearm", 32'(stall_status_o[3]), 1);
    cmd_stall_i[3] = 1'b0;
    step();
    check("R4 cmd low", 32'(stall_status_o[3]), 0);

    cmd_stall_i[3] = 1'b1; clr_feat_i = 1'b1; clr_feat_ep_i = 3;
    step();
    clr_feat_i = 1'b0;
    check("R5 clear wins", 32'(stall_status_o[3]), 0);

    cmd_stall_i[7] = 1'b1;
    step();
    step();
    check("R8 iso status", 32'(stall_status_o[7]), 0);
    check("R8 iso hold", 32'(hold_tx_o[7]), 0);
    token(7, 1'b1);
    check("R8 iso resp", 32'(resp_stall_o), 0);
    finish_xact();

    cmd_stall_i[0] = 1'b1;
    step();
    token(0, 1'b0);
    check("R10 ep0 out", 32'(resp_stall_o), 1);
    finish_xact();
    token(0, 1'b1);
    check("R10 ep0 in", 32'(resp_stall_o), 1);
    finish_xact();

    cmd_stall_i = '0;
    step();
    void'($urandom(32'h5A17));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(7) == 0) cmd_stall_i[$urandom_range(NUM_EP-1)] ^= 1'b1;
      if (c % 1000 == 999) iso_ep_i = NUM_EP'($urandom);
      clr_feat_i = ($urandom_range(9) == 0);
      clr_feat_ep_i = EPW'($urandom);
      tok_start_i = ($urandom_range(3) == 0);
      tok_ep_i = EPW'($urandom);
      tok_in_i = 1'($urandom);
      xact_end_i = ($urandom_range(2) == 0);
      step();
      compare_model();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule